// File: doc/BRIEF.md
# Time Base and Watchdog Timer

This block produces a programmable periodic time base and a watchdog timeout from one shared binary divider. It reports either of them on an active-low open-drain interrupt pin. A one-cycle `tick_in` pulse supplies the count rate. Crystal mode treats each pulse as a 32 kHz tick. The two 256 kHz modes, internal RC and external, first divide the pulses by eight in a 3-bit prescaler.

A 3-bit code selects the time base period. The pin level is a square wave of 1 Hz to 128 Hz, doubling with each code step. In watchdog mode, a 2-bit counter counts whole time base periods. At the fourth period the block sets a sticky flag that holds the pin low. Control arrives as one-cycle command strobes from a command decoder. The pin is modelled as a logical level (`irq_val`) and a pull-down enable (`irq_oe`) for the pad.

Top module: `timebase_watchdog`

## Requirements
- R1: After reset the interrupt output is disabled (`irq_oe` = 0), the system is powered down, the divider is stopped, time base routing is selected and the frequency code is 0.
- R2: `clk_src` encoding: 00 means crystal, and each `tick_in` advances the divider. 01 means internal RC and 10 or 11 mean external. In those three modes the divider advances once per eight `tick_in` pulses, counted from the last clear.
- R3: With frequency code k, the time base level is bit (14-k) of the 15-bit divider. Its period is 2^(15-k) divider steps: 32768 steps for code 0 (1 Hz) down to 256 steps for code 7 (128 Hz).
- R4: In watchdog mode the flag sets on the divider step that completes the fourth time base period since the last watchdog clear. The pin is then driven low.
- R5: Once set, the watchdog flag stays set until a watchdog-clear or an interrupt-disable strobe.
- R6: Clear-timer zeroes the divider and prescaler but keeps the watchdog period count. Clear-watchdog zeroes the divider, the prescaler, the period count and the flag.
- R7: Timer-enable runs the divider and routes the time base to the pin. Watchdog-enable runs the divider and routes the watchdog flag (`irq_val` = inverted flag). Timer-disable and watchdog-disable both stop the divider.
- R8: While interrupts are disabled the pin floats (`irq_oe` = 0). The cycle after an interrupt-disable strobe, `irq_oe` is 0.
- R9: A system-disable strobe in crystal or RC mode powers the block down: the divider holds and `irq_oe` is 0 until system-enable. In external mode the block always stays powered, and system-disable has no effect.
- R10: `irq_oe` is 1 exactly when interrupts are enabled, the block is powered and `irq_val` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-cycle count pulse from the selected clock source |
| clk_src | input | 2 | Source mode: 00 crystal, 01 RC, 1x external |
| cmd_sys_en | input | 1 | Power the block up |
| cmd_sys_dis | input | 1 | Power the block down (not in external mode) |
| cmd_timer_en | input | 1 | Run the divider, route the time base |
| cmd_timer_dis | input | 1 | Stop the divider |
| cmd_wdt_en | input | 1 | Run the divider, route the watchdog flag |
| cmd_wdt_dis | input | 1 | Stop the divider |
| cmd_clr_timer | input | 1 | Clear the divider and prescaler |
| cmd_clr_wdt | input | 1 | Clear the divider, prescaler, period count and flag |
| cmd_irq_en | input | 1 | Enable the interrupt pin |
| cmd_irq_dis | input | 1 | Float the pin and clear the flag |
| cmd_freq | input | 1 | Load `freq_sel` as the frequency code |
| freq_sel | input | 3 | Frequency code, 0 = 1 Hz to 7 = 128 Hz |
| irq_val | output | 1 | Logical pin level of the routed source |
| irq_oe | output | 1 | Pull the pin low |

## Verification
Every strobe and every counted `tick_in` acts at the rising edge that samples it. Both outputs depend only on registers and the source mode, so each result shows one edge after its cause. The bench changes its inputs 2 time units after a rising edge and compares both outputs with its model at every falling edge. The directed checks count edges from a clear. A time base edge at code 7 appears 128 steps after the clear. A watchdog timeout appears exactly 1024 steps after watchdog-enable, or 512 steps after a mid-run clear-timer with two periods already counted. The bench samples one edge before and one edge on each of these points.

// File: rtl/timebase_watchdog.sv
module timebase_watchdog #(
  parameter int PRE_BITS = 3,
  parameter int DIV_BITS = 15,
  parameter int WDT_BITS = 2,
  parameter int SEL_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_in,
  input  logic [1:0]          clk_src,
  input  logic                cmd_sys_en,
  input  logic                cmd_sys_dis,
  input  logic                cmd_timer_en,
  input  logic                cmd_timer_dis,
  input  logic                cmd_wdt_en,
  input  logic                cmd_wdt_dis,
  input  logic                cmd_clr_timer,
  input  logic                cmd_clr_wdt,
  input  logic                cmd_irq_en,
  input  logic                cmd_irq_dis,
  input  logic                cmd_freq,
  input  logic [SEL_BITS-1:0] freq_sel,
  output logic                irq_val,
  output logic                irq_oe
);

  localparam logic [PRE_BITS-1:0] PRE_LAST = '1;
  localparam logic [WDT_BITS-1:0] WDT_LAST = '1;
  localparam logic [DIV_BITS-1:0] ALL_ONES = '1;

  logic                sys_on, tb_on, route_wdt, irq_en, wdt_flag;
  logic [SEL_BITS-1:0] freq;
  logic [PRE_BITS-1:0] presc;
  logic [DIV_BITS-1:0] cnt;
  logic [WDT_BITS-1:0] wdt_cnt;

  wire ext_src    = clk_src[1];
  wire src32      = (clk_src == 2'b00);
  wire powered    = sys_on | ext_src;
  wire running    = powered & tb_on;
  wire clr_any    = cmd_clr_timer | cmd_clr_wdt;
  wire base_tick  = running & tick_in & (src32 | (presc == PRE_LAST));

  wire [DIV_BITS-1:0] mask = ALL_ONES >> freq;
  wire tb_out     = |(cnt & (mask ^ (mask >> 1)));
  wire period_end = base_tick & ((cnt & mask) == mask);
  wire wdt_step   = period_end & route_wdt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_on    <= 1'b0;
      tb_on     <= 1'b0;
      route_wdt <= 1'b0;
      irq_en    <= 1'b0;
      freq      <= '0;
    end else begin
      if (cmd_sys_en) sys_on <= 1'b1;
      else if (cmd_sys_dis && !ext_src) sys_on <= 1'b0;
      if (cmd_timer_en) begin
        tb_on     <= 1'b1;
        route_wdt <= 1'b0;
      end else if (cmd_wdt_en) begin
        tb_on     <= 1'b1;
        route_wdt <= 1'b1;
      end else if (cmd_timer_dis || cmd_wdt_dis) begin
        tb_on <= 1'b0;
      end
      if (cmd_irq_en) irq_en <= 1'b1;
      else if (cmd_irq_dis) irq_en <= 1'b0;
      if (cmd_freq) freq <= freq_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      cnt   <= '0;
    end else if (clr_any) begin
      presc <= '0;
      cnt   <= '0;
    end else begin
      if (running && tick_in && !src32) presc <= presc + 1'b1;
      if (base_tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_cnt  <= '0;
      wdt_flag <= 1'b0;
    end else if (cmd_clr_wdt) begin
      wdt_cnt  <= '0;
      wdt_flag <= 1'b0;
    end else begin
      if (wdt_step) wdt_cnt <= wdt_cnt + 1'b1;
      if (cmd_irq_dis) wdt_flag <= 1'b0;
      else if (wdt_step && wdt_cnt == WDT_LAST) wdt_flag <= 1'b1;
    end
  end

  assign irq_val = route_wdt ? ~wdt_flag : tb_out;
  assign irq_oe  = irq_en & powered & ~irq_val;

  assert_presc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running && !src32 && tick_in && presc != PRE_LAST && !clr_any |=> $stable(cnt))
    else $error("prescaler let the divider advance early");

  assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_flag && !(wdt_step && wdt_cnt == WDT_LAST) |=> !wdt_flag)
    else $error("watchdog flag set outside a fourth period end");

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_flag && !cmd_clr_wdt && !cmd_irq_dis |=> wdt_flag)
    else $error("watchdog flag dropped without a clear");

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (cnt == '0) && (presc == '0))
    else $error("clear did not zero the divider");

  assert_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq_dis |=> !irq_oe)
    else $error("pin driven after interrupt disable");

  assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !clr_any |=> $stable(cnt))
    else $error("divider moved while stopped");

endmodule

// File: tb/tb_timebase_watchdog.sv
module tb_timebase_watchdog;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick_in = 0;
  logic [1:0] clk_src = 2'b00;
  logic c_sys_en = 0, c_sys_dis = 0, c_t_en = 0, c_t_dis = 0, c_w_en = 0, c_w_dis = 0;
  logic c_clr_t = 0, c_clr_w = 0, c_irq_en = 0, c_irq_dis = 0, c_freq = 0;
  logic [2:0] freq_sel = 0;
  logic irq_val, irq_oe;

  int checks = 0, errors = 0, tick_mode = 0;
  string cur_req = "R1";

  timebase_watchdog dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .clk_src(clk_src),
    .cmd_sys_en(c_sys_en), .cmd_sys_dis(c_sys_dis), .cmd_timer_en(c_t_en),
    .cmd_timer_dis(c_t_dis), .cmd_wdt_en(c_w_en), .cmd_wdt_dis(c_w_dis),
    .cmd_clr_timer(c_clr_t), .cmd_clr_wdt(c_clr_w), .cmd_irq_en(c_irq_en),
    .cmd_irq_dis(c_irq_dis), .cmd_freq(c_freq), .freq_sel(freq_sel),
    .irq_val(irq_val), .irq_oe(irq_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #2;
    case (tick_mode)
      1: tick_in = 1'b1;
      2: tick_in = ~tick_in;
      default: tick_in = 1'b0;
    endcase
  end

  // behavioural reference model
  int m_cnt = 0, m_pre = 0, m_wdt = 0, m_f = 0;
  bit m_flag = 0, m_sys = 0, m_tb = 0, m_rt = 0, m_irq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_wdt = 0; m_f = 0;
      m_flag = 0; m_sys = 0; m_tb = 0; m_rt = 0; m_irq = 0;
    end else begin
      bit ext, s32, run, bt, pe;
      int per;
      ext = clk_src[1];
      s32 = (clk_src == 2'b00);
      run = (m_sys || ext) && m_tb;
      bt  = run && tick_in && (s32 || m_pre == 7);
      per = 1 << (15 - m_f);
      pe  = bt && ((m_cnt % per) == per - 1);
      if (c_clr_w) begin
        m_wdt = 0; m_flag = 0;
      end else begin
        if (c_irq_dis) m_flag = 0;
        else if (pe && m_rt && m_wdt == 3) m_flag = 1;
        if (pe && m_rt) m_wdt = (m_wdt + 1) % 4;
      end
      if (c_clr_t || c_clr_w) begin
        m_cnt = 0; m_pre = 0;
      end else begin
        if (run && tick_in && !s32) m_pre = (m_pre + 1) % 8;
        if (bt) m_cnt = (m_cnt + 1) % 32768;
      end
      if (c_sys_en) m_sys = 1; else if (c_sys_dis && !ext) m_sys = 0;
      if (c_t_en) begin m_tb = 1; m_rt = 0; end
      else if (c_w_en) begin m_tb = 1; m_rt = 1; end
      else if (c_t_dis || c_w_dis) m_tb = 0;
      if (c_irq_en) m_irq = 1; else if (c_irq_dis) m_irq = 0;
      if (c_freq) m_f = int'(freq_sel);
    end
  end

  function automatic bit exp_val();
    bit tb;
    tb = ((m_cnt >> (14 - m_f)) & 1) != 0;
    return m_rt ? !m_flag : tb;
  endfunction

  function automatic bit exp_oe();
    return m_irq && (m_sys || clk_src[1]) && !exp_val();
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "irq_val vs model", irq_val, exp_val());
      chk(cur_req, "irq_oe vs model", irq_oe, exp_oe());
    end
  end

  task automatic pulse(ref logic s);
    @(posedge clk); #2; s = 1'b1;
    @(posedge clk); #2; s = 1'b0;
  endtask

  task automatic set_freq(input logic [2:0] k);
    @(posedge clk); #2; freq_sel = k; c_freq = 1'b1;
    @(posedge clk); #2; c_freq = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_edges(3);
    at_neg();
    chk("R1", "reset irq_oe", irq_oe, 1'b0);
    chk("R1", "reset irq_val", irq_val, 1'b0);
    @(posedge clk); #2; rst_n = 1'b1;

    // R8: enabled but not powered -> floats
    cur_req = "R8";
    pulse(c_irq_en);
    pulse(c_t_en);
    wait_edges(5);
    at_neg();
    chk("R8", "unpowered pin floats", irq_oe, 1'b0);

    // R3: crystal source, code 7
    cur_req = "R3";
    clk_src = 2'b00;
    pulse(c_sys_en);
    set_freq(3'd7);
    tick_mode = 1;
    pulse(c_clr_t);
    wait_edges(127);
    at_neg();
    chk("R3", "code7 low half", irq_oe, 1'b1);
    wait_edges(1);
    at_neg();
    chk("R3", "code7 high half at 128", irq_oe, 1'b0);
    wait_edges(600);
    set_freq(3'd5);
    wait_edges(2100);
    tick_mode = 2;
    wait_edges(900);

    // R2: RC source with prescaler
    cur_req = "R2";
    tick_mode = 1;
    clk_src = 2'b01;
    set_freq(3'd7);
    pulse(c_clr_t);
    wait_edges(1023);
    at_neg();
    chk("R2", "prescaled low half", irq_oe, 1'b1);
    wait_edges(1);
    at_neg();
    chk("R2", "prescaled edge at 1024 ticks", irq_oe, 1'b0);
    tick_mode = 2;
    wait_edges(3000);
    tick_mode = 1;

    // R4: watchdog timeout
    cur_req = "R4";
    clk_src = 2'b00;
    pulse(c_t_dis);
    pulse(c_clr_w);
    pulse(c_w_en);
    wait_edges(1023);
    at_neg();
    chk("R4", "no timeout before 4th period", irq_oe, 1'b0);
    wait_edges(1);
    at_neg();
    chk("R4", "timeout pulls pin low", irq_oe, 1'b1);
    chk("R4", "timeout level", irq_val, 1'b0);

    // R5: sticky until clear
    cur_req = "R5";
    wait_edges(700);
    at_neg();
    chk("R5", "flag still held", irq_oe, 1'b1);
    pulse(c_clr_w);
    at_neg();
    chk("R5", "clear-watchdog releases pin", irq_oe, 1'b0);
    wait_edges(1100);
    at_neg();
    chk("R5", "second timeout", irq_oe, 1'b1);
    pulse(c_irq_dis);
    at_neg();
    chk("R8", "interrupt disable floats pin", irq_oe, 1'b0);
    pulse(c_irq_en);
    at_neg();
    chk("R5", "interrupt disable cleared the flag", irq_oe, 1'b0);

    // R6: clear-timer keeps period count
    cur_req = "R6";
    pulse(c_clr_w);
    wait_edges(600);
    pulse(c_clr_t);
    wait_edges(511);
    at_neg();
    chk("R6", "no timeout at 511 after clear-timer", irq_oe, 1'b0);
    wait_edges(1);
    at_neg();
    chk("R6", "timeout at 512 after clear-timer", irq_oe, 1'b1);

    // R7: routing and stop
    cur_req = "R7";
    pulse(c_clr_t);
    pulse(c_t_en);
    at_neg();
    chk("R7", "time base routed, low half", irq_oe, 1'b1);
    wait_edges(300);
    pulse(c_w_dis);
    wait_edges(400);
    pulse(c_t_en);
    wait_edges(400);

    // R9: power down on crystal, ignored on external
    cur_req = "R9";
    pulse(c_clr_t);
    pulse(c_sys_dis);
    at_neg();
    chk("R9", "powered down floats pin", irq_oe, 1'b0);
    wait_edges(500);
    pulse(c_sys_en);
    at_neg();
    chk("R9", "divider held through power down", irq_oe, 1'b1);
    clk_src = 2'b10;
    pulse(c_sys_dis);
    wait_edges(40);
    at_neg();
    chk("R9", "external mode ignores system disable", irq_oe, 1'b1);
    cur_req = "R10";
    wait_edges(2500);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule